// File: doc/BRIEF.md
# Quadrature Decimator and Upper-Sideband Demodulator

This block turns a stream of DC-free signed in-phase and quadrature samples into upper-sideband audio at a quarter of the input rate. Each arriving sample pair is pushed into a pair of raw history lines. On every fourth pair, a serial multiply-accumulate engine runs a 15-tap symmetric low-pass filter over both raw histories. The two filtered results then move into decimated history lines.

From the decimated quadrature history, a 15-tap antisymmetric Hilbert filter is computed. It is evaluated as four coefficient-times-difference products over the even taps. The result is subtracted from the in-phase value at the centre of its history. The difference is lifted to an unsigned mid-scale, clipped to the converter range and registered, together with a one-cycle strobe.

Samples arrive on a strobe, at most once every 16 clock cycles. That spacing leaves room for the serial filter to finish between input strobes.

Top module: `ssb_usb_demod`

## Requirements
- R1: While reset is held and after it is released, `audio_out` is 128 and `audio_valid` is 0 until the first decimated result is produced.
- R2: Counting accepted inputs from reset, `audio_valid` pulses exactly once for the 4th, 8th, 12th input and so on, and never at any other time.
- R3: `audio_valid` goes high exactly 17 clock edges after the edge that samples the triggering input, and it stays high for a single cycle.
- R4: Each filtered value is the sum over the 15 raw samples of sample times tap weight. The weights run from the oldest sample to the newest: 3,3,5,7,9,10,11,11,11,10,9,7,5,3,3. The sum is shifted arithmetically right by 8 bits.
- R5: Raw histories shift on every accepted input, and decimated histories shift once per decimated result. In both, the newest value sits at index 14 and index 0 holds the oldest. All histories start at zero after reset.
- R6: The Hilbert value is the sum of four products: (q0-q14)*315, (q2-q12)*440, (q4-q10)*734 and (q6-q8)*2202. The q terms are the decimated quadrature history. The sum is shifted arithmetically right by 12 bits, and all arithmetic is 32-bit signed.
- R7: The audio level is i7 of the decimated in-phase history, minus the Hilbert value, plus 128.
- R8: An audio level above 256 is output as 256.
- R9: An audio level below 0 is output as 0.
- R10: `audio_out` holds its value in every cycle in which `audio_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, at most once per 16 cycles |
| in_i | input | 12 | Signed in-phase sample |
| in_q | input | 12 | Signed quadrature sample |
| audio_out | output | 9 | Unsigned audio level, 0 to 256 |
| audio_valid | output | 1 | One-cycle strobe marking a new audio level |

## Verification
The edge that samples every fourth input starts the filter. The filtered pair is ready 15 edges later, the decimated histories move on the 16th edge, and the audio register loads on the 17th. The bench therefore records, at the falling edge after each triggering input, the cycle at which the result is due. It then expects the strobe and the value at the falling edge exactly 17 cycles on, and any early, late or missing strobe fails. Between strobes it watches `audio_out` on every falling edge, so that a change outside a strobe is caught.

// File: rtl/ssb_demod_pkg.sv
package ssb_demod_pkg;

  localparam int TAPS     = 15;
  localparam int CENTER   = (TAPS - 1) / 2;
  localparam int HB_PAIRS = 4;
  localparam int NCH      = 2;

  // Symmetric low-pass weights, folded around the centre tap.
  function automatic int lp_coef(input int k);
    int m;
    m = (k > CENTER) ? (TAPS - 1 - k) : k;
    case (m)
      0, 1:    return 3;
      2:       return 5;
      3:       return 7;
      4:       return 9;
      5:       return 10;
      default: return 11;
    endcase
  endfunction

  // Antisymmetric Hilbert weights for the even-tap pairs, outermost first.
  function automatic int hb_coef(input int p);
    case (p)
      0:       return 315;
      1:       return 440;
      2:       return 734;
      default: return 2202;
    endcase
  endfunction

endpackage

// File: rtl/ssb_shift_line.sv
module ssb_shift_line #(
  parameter int W      = 16,
  parameter int DEPTH  = 15,
  parameter int FIRST  = 0,
  parameter int STRIDE = 1,
  parameter int NOUT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [W-1:0]      din,
  output logic [NOUT*W-1:0] taps
);

  logic [W-1:0] mem [DEPTH];

  // Index DEPTH-1 takes the newest value; index 0 holds the oldest.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (shift_en) begin
      for (int k = 0; k < DEPTH - 1; k++) mem[k] <= mem[k+1];
      mem[DEPTH-1] <= din;
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_tap
    assign taps[g*W +: W] = mem[FIRST + g*STRIDE];
  end

endmodule

// File: rtl/ssb_fir_serial.sv
module ssb_fir_serial
  import ssb_demod_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [NCH-1:0][TAPS*IN_W-1:0]      raw_taps,
  output logic                               done,
  output logic [NCH-1:0][OUT_W-1:0]          filt
);

  localparam int IDX_W = $clog2(TAPS);

  logic                    busy;
  logic [IDX_W-1:0]        idx;
  logic signed [IN_W-1:0]  sel     [NCH];
  logic signed [ACC_W-1:0] acc_q   [NCH];
  logic signed [ACC_W-1:0] acc_nxt [NCH];

  // One tap per cycle for both channels.
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sel[c]     = raw_taps[c][int'(idx)*IN_W +: IN_W];
      acc_nxt[c] = acc_q[c] + ACC_W'(sel[c]) * ACC_W'(lp_coef(int'(idx)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        acc_q[c] <= '0;
        filt[c]  <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        for (int c = 0; c < NCH; c++) acc_q[c] <= '0;
      end else if (busy) begin
        for (int c = 0; c < NCH; c++) acc_q[c] <= acc_nxt[c];
        if (idx == IDX_W'(TAPS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int c = 0; c < NCH; c++) filt[c] <= OUT_W'(acc_nxt[c] >>> SHIFT);
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ssb_usb_stage.sv
module ssb_usb_stage
  import ssb_demod_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 9,
  parameter int HB_SHIFT = 12,
  parameter int DAC_MID  = 128,
  parameter int DAC_MAX  = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic [DW-1:0]            i_center,
  input  logic [2*HB_PAIRS*DW-1:0] q_even,
  output logic [OUT_W-1:0]         audio,
  output logic                     audio_valid
);

  localparam int NEV = 2 * HB_PAIRS;

  logic signed [ACC_W-1:0] hb_sum;
  logic signed [ACC_W-1:0] hb_val;
  logic signed [ACC_W-1:0] level;
  logic [OUT_W-1:0]        clipped;

  always_comb begin
    hb_sum = '0;
    for (int p = 0; p < HB_PAIRS; p++) begin
      hb_sum = hb_sum
             + (ACC_W'($signed(q_even[p*DW +: DW])) - ACC_W'($signed(q_even[(NEV-1-p)*DW +: DW])))
             * ACC_W'(hb_coef(p));
    end
    hb_val = hb_sum >>> HB_SHIFT;
    level  = ACC_W'($signed(i_center)) - hb_val + ACC_W'(DAC_MID);
    if (level > ACC_W'(DAC_MAX))  clipped = OUT_W'(DAC_MAX);
    else if (level < 0)           clipped = '0;
    else                          clipped = OUT_W'(level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      audio       <= OUT_W'(DAC_MID);
      audio_valid <= 1'b0;
    end else begin
      audio_valid <= fire;
      if (fire) audio <= clipped;
    end
  end

endmodule

// File: rtl/ssb_usb_demod.sv
module ssb_usb_demod
  import ssb_demod_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int DW       = 16,
  parameter int ACC_W    = 32,
  parameter int DECIM    = 4,
  parameter int LP_SHIFT = 8,
  parameter int HB_SHIFT = 12,
  parameter int OUT_W    = 9,
  parameter int DAC_MID  = 128,
  parameter int DAC_MAX  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_i,
  input  logic [IN_W-1:0]  in_q,
  output logic [OUT_W-1:0] audio_out,
  output logic             audio_valid
);

  localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int NEV    = 2 * HB_PAIRS;
  localparam int I_DEEP = CENTER + 1;

  logic [PH_W-1:0] phase;
  logic            trigger;
  logic            fir_done;
  logic            dec_moved;

  logic [NCH-1:0][TAPS*IN_W-1:0] raw_taps;
  logic [NCH-1:0][DW-1:0]        filt;
  logic [DW-1:0]                 i_center;
  logic [NEV*DW-1:0]             q_even;

  // Decimation phase: the filter runs when the count wraps.
  assign trigger = in_valid && (phase == PH_W'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      dec_moved <= 1'b0;
    end else begin
      dec_moved <= fir_done;
      if (in_valid) phase <= trigger ? '0 : phase + 1'b1;
    end
  end

  ssb_shift_line #(.W(IN_W), .DEPTH(TAPS), .FIRST(0), .STRIDE(1), .NOUT(TAPS)) u_raw_i (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_i), .taps(raw_taps[0])
  );

  ssb_shift_line #(.W(IN_W), .DEPTH(TAPS), .FIRST(0), .STRIDE(1), .NOUT(TAPS)) u_raw_q (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_q), .taps(raw_taps[1])
  );

  ssb_fir_serial #(.IN_W(IN_W), .OUT_W(DW), .ACC_W(ACC_W), .SHIFT(LP_SHIFT)) u_fir (
    .clk(clk), .rst(rst), .start(trigger), .raw_taps(raw_taps),
    .done(fir_done), .filt(filt)
  );

  // In-phase history only needs to reach the centre tap.
  ssb_shift_line #(.W(DW), .DEPTH(I_DEEP), .FIRST(0), .STRIDE(1), .NOUT(1)) u_dec_i (
    .clk(clk), .rst(rst), .shift_en(fir_done), .din(filt[0]), .taps(i_center)
  );

  // Quadrature history exposes only the even taps the Hilbert pairs use.
  ssb_shift_line #(.W(DW), .DEPTH(TAPS), .FIRST(0), .STRIDE(2), .NOUT(NEV)) u_dec_q (
    .clk(clk), .rst(rst), .shift_en(fir_done), .din(filt[1]), .taps(q_even)
  );

  ssb_usb_stage #(
    .DW(DW), .ACC_W(ACC_W), .OUT_W(OUT_W), .HB_SHIFT(HB_SHIFT),
    .DAC_MID(DAC_MID), .DAC_MAX(DAC_MAX)
  ) u_usb (
    .clk(clk), .rst(rst), .fire(dec_moved), .i_center(i_center), .q_even(q_even),
    .audio(audio_out), .audio_valid(audio_valid)
  );

endmodule

// File: rtl/ssb_demod_checks.sv
module ssb_demod_checks #(
  parameter int OUT_W   = 9,
  parameter int DECIM   = 4,
  parameter int DAC_MID = 128,
  parameter int DAC_MAX = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OUT_W-1:0] audio_out,
  input logic             audio_valid
);

  // lat is 1 after the triggering edge, so the result is due when it reads 18.
  localparam logic [5:0] DUE = 6'd18;

  logic [7:0] ph;
  logic [5:0] lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      lat <= '0;
    end else begin
      if (in_valid) ph <= (ph == 8'(DECIM - 1)) ? 8'd0 : ph + 8'd1;
      if (in_valid && ph == 8'(DECIM - 1)) lat <= 6'd1;
      else if (lat != 6'd0 && lat != 6'd63) lat <= lat + 6'd1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (audio_out == OUT_W'(DAC_MID) && !audio_valid));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    audio_valid |=> !audio_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    audio_valid |-> (lat == DUE));

  assert_due_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (lat == DUE) |-> audio_valid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    audio_out <= OUT_W'(DAC_MAX));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !audio_valid |-> $stable(audio_out));

endmodule

bind ssb_usb_demod ssb_demod_checks #(
  .OUT_W(OUT_W), .DECIM(DECIM), .DAC_MID(DAC_MID), .DAC_MAX(DAC_MAX)
) u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .audio_out(audio_out), .audio_valid(audio_valid)
);

// File: tb/ssb_usb_demod_tb_top.sv
module ssb_usb_demod_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [11:0] in_i = '0;
  logic [11:0] in_q = '0;
  logic [8:0] audio_out;
  logic       audio_valid;

  always #2 clk = ~clk;

  ssb_usb_demod dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .audio_out(audio_out), .audio_valid(audio_valid)
  );

  int tests = 0, fails = 0;
  int cyc = 0, trig_cyc = 0, nin = 0, pulses = 0;
  bit pend = 0, hold_bad = 0, mon_on = 0;
  longint exp_a = 0;
  logic [8:0] last_out = 9'd128;
  longint ri[15], rq[15], di[15], dq[15];
  int lpw[15] = '{3,3,5,7,9,10,11,11,11,10,9,7,5,3,3};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of one decimated step (R4 R5 R6 R7 R8 R9).
  function automatic longint model_step();
    longint fi = 0, fq = 0, h, a;
    for (int k = 0; k < 15; k++) begin
      fi += ri[k] * lpw[k];
      fq += rq[k] * lpw[k];
    end
    fi = fi >>> 8;
    fq = fq >>> 8;
    for (int k = 0; k < 14; k++) begin
      di[k] = di[k+1];
      dq[k] = dq[k+1];
    end
    di[14] = fi;
    dq[14] = fq;
    h = ((dq[0]-dq[14])*315 + (dq[2]-dq[12])*440 + (dq[4]-dq[10])*734 + (dq[6]-dq[8])*2202) >>> 12;
    a = di[7] - h + 128;
    if (a > 256) a = 256;
    else if (a < 0) a = 0;
    return a;
  endfunction

  task automatic send(int iv, int qv, int gap);
    bit trig;
    longint e = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 12'(iv);
    in_q = 12'(qv);
    for (int k = 0; k < 14; k++) begin
      ri[k] = ri[k+1];
      rq[k] = rq[k+1];
    end
    ri[14] = iv;
    rq[14] = qv;
    nin++;
    trig = (nin % 4 == 0);
    if (trig) e = model_step();
    @(negedge clk);
    in_valid = 1'b0;
    if (trig) begin
      trig_cyc = cyc;
      exp_a = e;
      pend = 1'b1;
    end
    repeat (gap - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (audio_valid) begin
        pulses++;
        check(pend && (cyc == trig_cyc + 17), "R3 R2 strobe timing", cyc - trig_cyc, 17);
        if (exp_a == 256)    check(audio_out == 9'(exp_a), "R8 clip high", audio_out, exp_a);
        else if (exp_a == 0) check(audio_out == 9'(exp_a), "R9 clip low", audio_out, exp_a);
        else                 check(audio_out == 9'(exp_a), "R4 R5 R6 R7 audio value", audio_out, exp_a);
        check(!hold_bad, "R10 hold between strobes", hold_bad, 0);
        hold_bad = 1'b0;
        pend = 1'b0;
      end else begin
        if (audio_out != last_out) hold_bad = 1'b1;
        if (pend && cyc > trig_cyc + 17) begin
          check(1'b0, "R3 missing strobe", cyc - trig_cyc, 17);
          pend = 1'b0;
        end
      end
      last_out = audio_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 15; k++) begin
      ri[k] = 0; rq[k] = 0; di[k] = 0; dq[k] = 0;
    end
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    check(audio_out == 9'd128 && !audio_valid, "R1 during reset", audio_out, 128);
    rst = 1'b0;
    @(negedge clk);
    check(audio_out == 9'd128 && !audio_valid, "R1 after reset", audio_out, 128);
    last_out = audio_out;
    mon_on = 1'b1;

    // Silence, then a steady positive level driving the clip-high path.
    for (int n = 0; n < 8; n++) send(0, 0, 16);
    for (int n = 0; n < 40; n++) send(2000, 0, 16);
    // Steady negative level driving the clip-low path.
    for (int n = 0; n < 40; n++) send(-2000, 0, 17);
    // Settle, then a quadrature impulse exercising the Hilbert taps.
    for (int n = 0; n < 60; n++) send(0, 0, 16);
    send(0, 2047, 16);
    for (int n = 0; n < 67; n++) send(0, 0, 16);
    send(0, -2048, 18);
    for (int n = 0; n < 67; n++) send(0, 0, 16);
    // Random stimulus, small then full scale.
    for (int n = 0; n < 200; n++)
      send(int'($urandom_range(600)) - 300, int'($urandom_range(600)) - 300,
           16 + int'($urandom_range(7)));
    for (int n = 0; n < 200; n++)
      send(int'($urandom_range(4095)) - 2048, int'($urandom_range(4095)) - 2048,
           16 + int'($urandom_range(7)));

    repeat (40) @(negedge clk);
    check(pulses == nin / 4, "R2 strobe count", pulses, nin / 4);
    check(!pend, "R3 final strobe delivered", pend, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule